// File: doc/BRIEF.md
# Cycle Counter with Compare Interrupt

This block is a per-processor interval timer. A free-running cycle counter advances by one on every clock, and a single compare register holds the point in time at which an interrupt event is wanted. Both share one register address: a read there returns the live counter, and a write there loads the compare value. The compare register can be written but never read back.

When the low compare-width bits of the counter equal the compare value, a sticky pending flag is set. A software acknowledge pulse clears it. The interrupt line is the pending flag gated by an enable bit held in a second, control address. Each instance runs on its own, with no link to any other. The counter is 64 bits wide by default and may be built 32 bits wide.

A compare value already passed by the counter raises nothing until the low counter bits wrap round to it. Software normally programs "now plus one period" and re-arms the timer from the interrupt handler.

Top module: `cyc_cmp_timer`

## Requirements
- R1: The counter leaves reset at zero and increases by exactly one on every clock. A read with `bus_sel` = 0 returns the full-width counter value of that cycle.
- R2: After reset the compare register holds all ones, the enable bit is 0, nothing is pending and `irq` is low. The first event therefore comes when the low bits reach all ones.
- R3: A write with `bus_sel` = 0 loads the compare register, and the new value is compared from the next clock on. A read with `bus_sel` = 0 never returns the compare value.
- R4: The pending flag is seen one clock after the cycle in which the low CMP_W counter bits equal the compare value. The upper counter bits take no part, so an unchanged compare value matches again every 2^CMP_W cycles.
- R5: The pending flag stays set until a cycle with `ack` high clears it at the next clock. If a match and `ack` fall in the same cycle, the flag stays set.
- R6: Reads with `bus_sel` = 1 return the enable in bit 0 and the pending flag in bit 1, with zeros above. Writes with `bus_sel` = 1 load the enable from `bus_wdata` bit 0. `irq` is high exactly when both the pending flag and the enable are 1.
- R7: A write to the compare register does not clear a pending flag that is already set.
- R8: A compare value below the low counter bits raises no event until the low bits wrap round and reach it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_sel | input | 1 | Register select: 0 counter/compare, 1 control |
| bus_wdata | input | CMP_W | Write data |
| bus_rdata | output | CNT_W | Read data for the selected register |
| ack | input | 1 | Clears the pending flag |
| irq | output | 1 | Interrupt, pending flag gated by the enable |

## Verification
A small build (12-bit counter, 8-bit compare) is swept over every compare value, each written at an arbitrary counter phase. The delay from the write to the pending flag must equal the modular distance plus two clocks, which separates values ahead of the counter from values already passed that have to wait for the wrap. Holding one value across two matches shows that the upper counter bits are ignored. Acknowledge pulses placed on and off the match cycle separate set-over-clear priority from plain clearing. A cycle-by-cycle model compares reads and `irq` on every clock, with the enable switched on and off. A default-width instance confirms the reset values and one programmed event.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

    // register select values on the bus
    typedef enum logic {
        SEL_TIME = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    // control / status word seen at SEL_CTRL
    typedef struct packed {
        logic pend;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic sel_write(input logic wr, input reg_sel_e sel,
                                       input reg_sel_e target);
        return wr && (sel == target);
    endfunction

endpackage

// File: rtl/ct_counter.sv
module ct_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt_o = cnt_q;

    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cnt_q - $past(cnt_q)) == CNT_W'(1));

endmodule

// File: rtl/ct_compare.sv
module ct_compare #(
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [CMP_W-1:0] ld_val,
    input  logic [CMP_W-1:0] cnt_lo,
    output logic             match_o
);
    logic [CMP_W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (rst)     cmp_q <= '1;
        else if (ld) cmp_q <= ld_val;
    end

    assign match_o = (cnt_lo == cmp_q);

    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ld)) |-> cmp_q == $past(ld_val));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ld)) |-> $stable(cmp_q));

endmodule

// File: rtl/ct_irq.sv
module ct_irq
    import cyc_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  match,
    input  logic  ack,
    input  logic  en_ld,
    input  logic  en_val,
    output ctrl_t state_o,
    output logic  irq_o
);
    ctrl_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (match)    st_q.pend <= 1'b1;
            else if (ack) st_q.pend <= 1'b0;
            if (en_ld)    st_q.en   <= en_val;
        end
    end

    assign state_o = st_q;
    assign irq_o   = st_q.pend & st_q.en;

    assert_set_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(match)) |-> st_q.pend);

    assert_cause_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(st_q.pend)) |-> $past(match));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(st_q.pend) && !$past(ack)) |-> st_q.pend);

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ack) && !$past(match)) |-> !st_q.pend);

endmodule

// File: rtl/cyc_cmp_timer.sv
module cyc_cmp_timer
    import cyc_timer_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_sel,
    input  logic [CMP_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             ack,
    output logic             irq
);
    localparam int PAD_W = CNT_W - CTRL_W;

    reg_sel_e         sel;
    logic [CNT_W-1:0] cnt;
    logic             match;
    logic             cmp_ld;
    logic             en_ld;
    ctrl_t            st;

    assign sel    = reg_sel_e'(bus_sel);
    assign cmp_ld = sel_write(bus_wr, sel, SEL_TIME);
    assign en_ld  = sel_write(bus_wr, sel, SEL_CTRL);

    ct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt)
    );

    ct_compare #(.CMP_W(CMP_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .ld      (cmp_ld),
        .ld_val  (bus_wdata),
        .cnt_lo  (cnt[CMP_W-1:0]),
        .match_o (match)
    );

    ct_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .match   (match),
        .ack     (ack),
        .en_ld   (en_ld),
        .en_val  (bus_wdata[0]),
        .state_o (st),
        .irq_o   (irq)
    );

    always_comb begin
        case (sel)
            SEL_CTRL: bus_rdata = {{PAD_W{1'b0}}, st};
            default:  bus_rdata = cnt;
        endcase
    end

    assert_pend_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(st.pend) && $past(cmp_ld) && !$past(ack)) |-> st.pend);

    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (st.en && st.pend));

endmodule

// File: tb/cyc_cmp_timer_tb.sv
module cyc_cmp_timer_tb;
    localparam int SW = 12;
    localparam int SC = 8;
    localparam int WDOG = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          wr = 0, sel = 0, ack = 0;
    logic [SC-1:0] wdata = '0;
    logic [SW-1:0] rdata;
    logic          irq;

    logic          w_wr = 0, w_sel = 0;
    logic [31:0]   w_wdata = '0;
    logic [63:0]   w_rdata;
    logic          w_irq;

    cyc_cmp_timer #(.CNT_W(SW), .CMP_W(SC)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_sel(sel), .bus_wdata(wdata),
        .bus_rdata(rdata), .ack(ack), .irq(irq));

    cyc_cmp_timer u_dut_wide (
        .clk(clk), .rst(rst), .bus_wr(w_wr), .bus_sel(w_sel), .bus_wdata(w_wdata),
        .bus_rdata(w_rdata), .ack(1'b0), .irq(w_irq));

    int tests = 0, fails = 0;
    bit scb_on = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model of the small instance, built from the requirements
    logic [SW-1:0] m_cnt;
    logic [SC-1:0] m_cmp;
    logic          m_pend, m_en;
    logic [63:0]   cyc;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_cmp <= '1; m_pend <= 0; m_en <= 0; cyc <= '0;
        end else begin
            m_cnt <= m_cnt + 1'b1;
            cyc   <= cyc + 1;
            if (wr && !sel) m_cmp <= wdata;
            if (wr && sel)  m_en  <= wdata[0];
            if (m_cnt[SC-1:0] == m_cmp) m_pend <= 1'b1;
            else if (ack)               m_pend <= 1'b0;
        end
    end

    // per-cycle scoreboard
    always @(negedge clk) begin
        if (scb_on && !rst) begin
            if (!sel) chk("R1 counter read", 64'(rdata), 64'(m_cnt));
            else      chk("R6 control read", 64'(rdata), 64'({m_pend, m_en}));
            chk("R6 irq gating", 64'(irq), 64'(m_pend & m_en));
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > WDOG) begin
            fails++;
            $display("FAIL R1 watchdog: cycles %0d expected < %0d", wd, WDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wait_pend(output int k);
        k = 1;
        while (!rdata[1] && k < 600) begin
            @(negedge clk); k++;
        end
    endtask

    initial begin
        int k;
        logic [SW-1:0] c;
        logic [SC-1:0] d;
        logic [63:0]   wc;

        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 counter at reset", 64'(rdata), 64'd0);
        chk("R2 irq at reset", 64'(irq), 64'd0);
        chk("R2 wide counter at reset", w_rdata, 64'd0);
        sel = 1; w_sel = 1; #1;
        chk("R2 control at reset", 64'(rdata), 64'd0);
        chk("R2 wide control at reset", w_rdata, 64'd0);
        rst = 0;
        scb_on = 1;

        // R2 reset compare is all ones: first event after low bits hit 255
        @(negedge clk);
        wait_pend(k);
        chk("R2 first pending counter", 64'(m_cnt), 64'd256);
        chk("R2 wide no event", 64'(w_rdata[1]), 64'd0);

        // R1 wide counter, R3 wide compare load
        w_sel = 0; #1;
        chk("R1 wide counter", w_rdata, cyc);
        wc = cyc;
        w_wr = 1; w_wdata = 32'(wc + 40);
        @(negedge clk); w_wr = 0;
        chk("R3 read returns counter not compare", w_rdata, wc + 1);
        w_sel = 1;
        while (!w_rdata[1] && cyc < wc + 100) @(negedge clk);
        chk("R4 wide event timing", cyc, wc + 41);

        // R6 enable the small instance
        wr = 1; sel = 1; wdata = 8'h01;
        @(negedge clk); wr = 0;
        chk("R6 irq follows pending once enabled", 64'(irq), 64'd1);

        // R4 / R8 sweep over every compare value
        for (int v = 0; v < 256; v++) begin
            ack = 1; @(negedge clk); ack = 0;
            c = m_cnt;
            sel = 0; wr = 1; wdata = SC'(v);
            @(negedge clk); wr = 0; sel = 1; #1;
            d = SC'(v) - SC'(c + 1'b1);
            wait_pend(k);
            if (SC'(v) < SC'(c + 1'b1))
                chk("R8 passed value waits for wrap", 64'(k), 64'(d) + 2);
            else
                chk("R4 match delay", 64'(k), 64'(d) + 2);
        end

        // R7 compare write keeps pending
        sel = 0; wr = 1; wdata = SC'(m_cnt + 100);
        @(negedge clk); wr = 0; sel = 1; #1;
        chk("R7 pending kept after compare write", 64'(rdata[1]), 64'd1);

        // R4 upper bits ignored: same compare matches again after 2^SC
        ack = 1; @(negedge clk); ack = 0; #1;
        wait_pend(k);
        ack = 1; @(negedge clk); ack = 0; #1;
        chk("R5 ack clears", 64'(rdata[1]), 64'd0);
        wait_pend(k);
        chk("R4 rematch period", 64'(k), 64'd256);

        // R5 ack on the match cycle: set wins
        ack = 1; @(negedge clk); ack = 0;
        c = m_cnt;
        sel = 0; wr = 1; wdata = SC'(c + 3);
        @(negedge clk); wr = 0; sel = 1;
        @(negedge clk);
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0; #1;
        chk("R5 set wins over ack", 64'(rdata[1]), 64'd1);
        ack = 1; @(negedge clk); ack = 0; #1;
        chk("R5 ack without match clears", 64'(rdata[1]), 64'd0);
        chk("R5 irq drops", 64'(irq), 64'd0);

        // R6 disable masks a pending event
        wait_pend(k);
        wr = 1; wdata = 8'h00;
        @(negedge clk); wr = 0; #1;
        chk("R6 masked irq", 64'(irq), 64'd0);
        chk("R6 pending still visible", 64'(rdata), 64'b10);

        scb_on = 0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule